// File: doc/BRIEF.md
# Vectored Interrupt Controller with Acknowledge

This block collects seven level-type interrupt conditions from neighbouring logic, plus one change-detect flag built from four general input pins, into an 8-bit status word. A write-only mask selects which status bits may pull the active-low interrupt request. The status word always reads back the raw conditions, whatever the mask holds.

A processor reaches the registers through a synchronous bus. The bus has an active-low select, a read/write level, a 4-bit address, separate 8-bit write and read data, and an active-low data-acknowledge strobe. The strobe answers each access after a fixed number of clock edges. An active-low interrupt-acknowledge input starts a vector cycle. If an enabled interrupt is pending, the block places its 8-bit vector register on the read data and acknowledges. If none is pending, the acknowledge strobe never asserts.

Reset is synchronous and active-high. Every output is registered.

Top module: `vic_ack`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `irq_n` and `dack_n` are 1 and `rdata_oe` is 0. After reset the mask is 0x00, so active conditions do not raise a request. The vector register reads 0x0F, and both the status register and the change register read 0x00.
- R2: `irq_n` goes low exactly two clock edges after a source input changes, when any status bit whose mask bit is 1 is set. It is high otherwise. After one edge it still shows the old value.
- R3: A read at address 0x5 returns status. Bits 6:0 are `src` as sampled on the previous edge, and bit 7 is the input-change flag. The mask has no effect on this value. A write to 0x5 loads the mask, which cannot be read back.
- R4: With `sel_n` low, `dack_n` is still high after the first rising edge and low after the second. It stays low while `sel_n` is low and returns high on the first edge at which `sel_n` is sampled high. For a read, `rdata` is valid and `rdata_oe` is 1 while `dack_n` is low.
- R5: An acknowledge cycle (`iack_n` low, with priority over `sel_n`) that finds an unmasked status bit pending drives the vector on `rdata`, with `rdata_oe` set. `dack_n` follows the R4 timing.
- R6: An acknowledge cycle with nothing unmasked pending leaves `dack_n` high and `rdata_oe` low for as long as `iack_n` stays low.
- R7: Address 0xC holds the vector register, which can be both written and read.
- R8: Each of the four pins records a delta bit on any change of its sampled level, whether or not it is enabled. The input-change flag (status bit 7) sets only when a pin whose enable bit is 1 changes. A write to 0x4 loads the enables from `wdata[3:0]`.
- R9: A read at 0x4 returns the delta bits in bits 7:4 and the current pin levels in bits 3:0. That read clears the delta bits and the input-change flag, unless a new change arrives on the same edge.
- R10: Writes to unmapped addresses change no register, and reads of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Register access select, active low |
| iack_n | input | 1 | Interrupt acknowledge cycle, active low |
| wr_n | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data / interrupt vector |
| rdata_oe | output | 1 | Read data is being driven |
| dack_n | output | 1 | Data acknowledge, active low |
| irq_n | output | 1 | Interrupt request, active low |
| src | input | 7 | Level interrupt conditions |
| pin_in | input | 4 | General input pins watched for change |

## Verification
Three kinds of internal fault show at the ports in different ways.

A stuck or wrong mask bit shows on `irq_n` two edges after the matching source moves. The same fault also shows as a missing or extra acknowledge on the next vector cycle.

A sticky change flag or delta bit that fails to set or to clear shows in the next read of the status or change register, and on `irq_n` once the flag is unmasked.

A miscounted handshake shows at once, as `dack_n` asserting one edge early or late relative to the select.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_CHG  = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_STAT = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_VEC  = 4'hC;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_READ,
    BUS_WRITE,
    BUS_IACK
  } bus_kind_e;
endpackage

// File: rtl/vic_bus_seq.sv
module vic_bus_seq
  import vic_pkg::*;
#(
  parameter int ACK_DELAY = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sel_n,
  input  logic      iack_n,
  input  logic      wr_n,
  input  logic      pending,
  output logic      active,
  output logic      commit,
  output bus_kind_e kind,
  output logic      dack_n
);
  localparam int CW = $clog2(ACK_DELAY + 1);
  localparam logic [CW-1:0] LAST = CW'(ACK_DELAY - 1);

  logic [CW-1:0] cnt;
  logic          done;

  always_comb begin
    if (!iack_n)     kind = BUS_IACK;
    else if (!sel_n) kind = wr_n ? BUS_READ : BUS_WRITE;
    else             kind = BUS_IDLE;
  end

  assign active = (kind != BUS_IDLE);
  assign commit = active && !done && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      done   <= 1'b0;
      dack_n <= 1'b1;
    end else if (!active) begin
      cnt    <= '0;
      done   <= 1'b0;
      dack_n <= 1'b1;
    end else if (commit) begin
      done   <= 1'b1;
      dack_n <= (kind == BUS_IACK) ? !pending : 1'b0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vic_chg_detect.sv
module vic_chg_detect #(
  parameter int N_PIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_PIN-1:0] pin_in,
  input  logic [N_PIN-1:0] chg_en,
  input  logic             clr,
  output logic [N_PIN-1:0] pin_lvl,
  output logic [N_PIN-1:0] delta,
  output logic             flag
);
  logic [N_PIN-1:0] pin_prev;
  logic [N_PIN-1:0] edge_hit;

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    assign edge_hit[i] = pin_lvl[i] ^ pin_prev[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_lvl[i]  <= 1'b0;
        pin_prev[i] <= 1'b0;
        delta[i]    <= 1'b0;
      end else begin
        pin_lvl[i]  <= pin_in[i];
        pin_prev[i] <= pin_lvl[i];
        delta[i]    <= edge_hit[i] | (delta[i] & !clr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (|(edge_hit & chg_en)) | (flag & !clr);
  end
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int          N_SRC    = 7,
  parameter int          N_PIN    = 4,
  parameter int          DW       = 8,
  parameter logic [7:0]  VEC_INIT = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              commit,
  input  bus_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [N_SRC-1:0]  src,
  input  logic              chg_flag,
  input  logic [N_PIN-1:0]  chg_delta,
  input  logic [N_PIN-1:0]  pin_lvl,
  input  logic              pending,
  output logic [DW-1:0]     status,
  output logic [DW-1:0]     mask,
  output logic [N_PIN-1:0]  chg_en,
  output logic              chg_clr,
  output logic [DW-1:0]     rdata,
  output logic              rdata_oe
);
  logic [N_SRC-1:0] src_q;
  logic [DW-1:0]    vec;
  logic [DW-1:0]    chg_word;
  logic [DW-1:0]    rd_word;
  logic             unused_hi;

  assign unused_hi = ^wdata[DW-1:N_PIN];
  assign status    = {chg_flag, src_q};
  assign chg_clr   = commit && (kind == BUS_READ) && (addr == ADR_CHG);

  always_comb begin
    chg_word = '0;
    chg_word[2*N_PIN-1:0] = {chg_delta, pin_lvl};
  end

  always_comb begin
    case (addr)
      ADR_STAT: rd_word = status;
      ADR_VEC:  rd_word = vec;
      ADR_CHG:  rd_word = chg_word;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      mask     <= '0;
      vec      <= DW'(VEC_INIT);
      chg_en   <= '0;
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      src_q <= src;
      if (!active) begin
        rdata_oe <= 1'b0;
      end else if (commit) begin
        case (kind)
          BUS_WRITE: begin
            case (addr)
              ADR_STAT: mask   <= wdata;
              ADR_VEC:  vec    <= wdata;
              ADR_CHG:  chg_en <= wdata[N_PIN-1:0];
              default:  ;
            endcase
          end
          BUS_READ: begin
            rdata    <= rd_word;
            rdata_oe <= 1'b1;
          end
          BUS_IACK: begin
            if (pending) begin
              rdata    <= vec;
              rdata_oe <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vic_irq.sv
module vic_irq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] mask,
  output logic          pending,
  output logic          irq_n
);
  assign pending = |(status & mask);

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= !pending;
  end
endmodule

// File: rtl/vic_ack.sv
module vic_ack
  import vic_pkg::*;
#(
  parameter int         N_SRC     = 7,
  parameter int         N_PIN     = 4,
  parameter int         ACK_DELAY = 2,
  parameter logic [7:0] VEC_INIT  = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              iack_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_SRC:0]    wdata,
  output logic [N_SRC:0]    rdata,
  output logic              rdata_oe,
  output logic              dack_n,
  output logic              irq_n,
  input  logic [N_SRC-1:0]  src,
  input  logic [N_PIN-1:0]  pin_in
);
  localparam int DW = N_SRC + 1;

  logic             active;
  logic             commit;
  bus_kind_e        kind;
  logic             pending;
  logic [DW-1:0]    status;
  logic [DW-1:0]    mask;
  logic [N_PIN-1:0] chg_en;
  logic             chg_clr;
  logic [N_PIN-1:0] pin_lvl;
  logic [N_PIN-1:0] chg_delta;
  logic             chg_flag;

  vic_bus_seq #(.ACK_DELAY(ACK_DELAY)) u_seq (
    .clk(clk), .rst(rst), .sel_n(sel_n), .iack_n(iack_n), .wr_n(wr_n),
    .pending(pending), .active(active), .commit(commit), .kind(kind),
    .dack_n(dack_n)
  );

  vic_chg_detect #(.N_PIN(N_PIN)) u_chg (
    .clk(clk), .rst(rst), .pin_in(pin_in), .chg_en(chg_en), .clr(chg_clr),
    .pin_lvl(pin_lvl), .delta(chg_delta), .flag(chg_flag)
  );

  vic_regs #(.N_SRC(N_SRC), .N_PIN(N_PIN), .DW(DW), .VEC_INIT(VEC_INIT)) u_regs (
    .clk(clk), .rst(rst), .active(active), .commit(commit), .kind(kind),
    .addr(addr), .wdata(wdata), .src(src), .chg_flag(chg_flag),
    .chg_delta(chg_delta), .pin_lvl(pin_lvl), .pending(pending),
    .status(status), .mask(mask), .chg_en(chg_en), .chg_clr(chg_clr),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  vic_irq #(.DW(DW)) u_irq (
    .clk(clk), .rst(rst), .status(status), .mask(mask),
    .pending(pending), .irq_n(irq_n)
  );
endmodule

// File: rtl/vic_ack_chk.sv
module vic_ack_chk (
  input logic clk,
  input logic rst,
  input logic sel_n,
  input logic iack_n,
  input logic dack_n,
  input logic irq_n,
  input logic rdata_oe,
  input logic pending
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (irq_n && dack_n && !rdata_oe));

  // R2
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n == !$past(pending));

  // R4
  dack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_n && iack_n) |=> dack_n);

  // R4
  dack_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dack_n) |-> ($past(!sel_n || !iack_n) && $past(!sel_n || !iack_n, 2)));

  // R6
  iack_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dack_n) && $past(!iack_n)) |-> $past(pending));

  // R5
  iack_drive_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(dack_n) && $past(!iack_n)) |-> rdata_oe);
endmodule

bind vic_ack vic_ack_chk u_chk (
  .clk(clk), .rst(rst), .sel_n(sel_n), .iack_n(iack_n), .dack_n(dack_n),
  .irq_n(irq_n), .rdata_oe(rdata_oe), .pending(pending)
);

// File: tb/vic_ack_test.sv
module vic_ack_test;
  localparam int CLK_PERIOD = 10;
  localparam int NTBL = 10;
  // entry: {write, addr[3:0], wdata[7:0], expected read[7:0]}
  localparam logic [20:0] TBL [NTBL] = '{
    {1'b0, 4'h5, 8'h00, 8'h00},
    {1'b1, 4'hC, 8'h5A, 8'h00},
    {1'b0, 4'hC, 8'h00, 8'h5A},
    {1'b1, 4'h5, 8'h82, 8'h00},
    {1'b0, 4'h5, 8'h00, 8'h00},
    {1'b1, 4'h7, 8'hFF, 8'h00},
    {1'b0, 4'hC, 8'h00, 8'h5A},
    {1'b0, 4'h7, 8'h00, 8'h00},
    {1'b1, 4'h4, 8'h03, 8'h00},
    {1'b0, 4'h4, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n = 1'b1, iack_n = 1'b1, wr_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_oe, dack_n, irq_n;
  logic [6:0] src = '0;
  logic [3:0] pin_in = '0;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  vic_ack uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .iack_n(iack_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .dack_n(dack_n), .irq_n(irq_n), .src(src), .pin_in(pin_in)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [3:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    @(negedge clk);
    sel_n = 1'b0; wr_n = !wr; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    chk("R4 no ack after one edge", dack_n, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R4 ack after two edges", dack_n, 1'b0);
    if (!wr) chk("R4 read drives bus", rdata_oe, 1'b1);
    rd = rdata;
    sel_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R4 ack released", dack_n, 1'b1);
  endtask

  task automatic iack_op(input logic expect_ack, input logic [7:0] expect_vec);
    @(negedge clk);
    iack_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (expect_ack) begin
      chk("R5 vector acknowledged", dack_n, 1'b0);
      chk("R5 vector driven", rdata_oe, 1'b1);
      chk("R5 vector value", rdata, expect_vec);
    end else begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R6 no ack without pending", dack_n, 1'b1);
      chk("R6 bus not driven", rdata_oe, 1'b0);
    end
    iack_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R4 ack idle after iack", dack_n, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 irq idle in reset", irq_n, 1'b1);
    chk("R1 dack idle in reset", dack_n, 1'b1);
    chk("R1 bus idle in reset", rdata_oe, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    do_reset();
    bus_op(1'b0, 4'hC, 8'h00, rd); chk("R1 vector reset value", rd, 8'h0F);

    for (int i = 0; i < NTBL; i++) begin
      bus_op(TBL[i][20], TBL[i][19:16], TBL[i][15:8], rd);
      if (!TBL[i][20]) chk($sformatf("R3/R7/R10 table entry %0d", i), rd, TBL[i][7:0]);
    end

    // mask = 0x82 now; src bits 0 and 2 are masked
    @(negedge clk); src = 7'h05;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R2 masked sources keep irq high", irq_n, 1'b1);
    bus_op(1'b0, 4'h5, 8'h00, rd); chk("R3 status shows masked bits", rd, 8'h05);

    @(negedge clk); src = 7'h07;
    @(posedge clk); @(negedge clk);
    chk("R2 irq unchanged after one edge", irq_n, 1'b1);
    @(posedge clk); @(negedge clk);
    chk("R2 irq low after two edges", irq_n, 1'b0);

    iack_op(1'b1, 8'h5A);

    @(negedge clk); src = 7'h00;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R2 irq released", irq_n, 1'b1);
    iack_op(1'b0, 8'h00);

    // pin 2 is not enabled (enables = 0x3)
    @(negedge clk); pin_in = 4'b0100;
    repeat (4) @(posedge clk);
    bus_op(1'b0, 4'h5, 8'h00, rd); chk("R8 disabled pin leaves flag clear", rd, 8'h00);
    chk("R8 irq stays high", irq_n, 1'b1);
    bus_op(1'b0, 4'h4, 8'h00, rd); chk("R8 delta recorded for disabled pin", rd, 8'h44);
    bus_op(1'b0, 4'h4, 8'h00, rd); chk("R9 delta cleared by read", rd, 8'h04);

    // pin 0 is enabled
    @(negedge clk); pin_in = 4'b0101;
    repeat (4) @(posedge clk); @(negedge clk);
    chk("R8 enabled pin change raises irq", irq_n, 1'b0);
    bus_op(1'b0, 4'h5, 8'h00, rd); chk("R8 flag in status bit 7", rd, 8'h80);
    bus_op(1'b0, 4'h4, 8'h00, rd); chk("R9 change register value", rd, 8'h15);
    bus_op(1'b0, 4'h5, 8'h00, rd); chk("R9 flag cleared by read", rd, 8'h00);
    chk("R9 irq released after clear", irq_n, 1'b1);

    // mid-run reset
    @(negedge clk); pin_in = 4'b0000;
    repeat (3) @(posedge clk);
    do_reset();
    @(negedge clk); src = 7'h02;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R1 cleared mask keeps irq high", irq_n, 1'b1);
    bus_op(1'b0, 4'hC, 8'h00, rd); chk("R1 vector back to reset", rd, 8'h0F);
    bus_op(1'b0, 4'h5, 8'h00, rd); chk("R1 status after reset", rd, 8'h02);
    bus_op(1'b0, 4'h4, 8'h00, rd); chk("R1 change register after reset", rd, 8'h00);
    iack_op(1'b0, 8'h00);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule